// File: doc/BRIEF.md
# Successive-Approximation Companding Encoder Sequencer

This block is the digital controller of a segmented analog-to-digital conversion. After a start pulse it runs a bit-serial search: it drives a trial code (chord field plus step field, with a rectify flag) to an external DAC. It then reads one comparator bit that reports whether the rectified input is at or above the trial level. The result is an 8-bit companded word, in either of the two common telephony laws, selected per conversion.

The search settles one bit per clock cycle. The polarity is decided first against a zero level. The three chord bits follow, with the step field at zero. The four step bits come last. Each kept bit stays set while lower bits are tried. A law-specific inversion pattern is applied to the magnitude bits when the word is registered. The external DAC produces chord levels whose step size doubles from one chord to the next, so the seven chords above zero cover about 42 dB.

Top module: `sar_compand_enc`

## Requirements
- R1: While reset is applied and after it ends, `conv_busy`, `conv_done` and `pcm_code` are 0, and `dac_chord`, `dac_step` and `dac_rectify` are 0.
- R2: A `conv_start` sampled high at a clock edge while idle starts a conversion. `conv_busy` is high from the next cycle. `conv_done` is high for exactly one cycle, following the eighth clock edge after the starting edge, and `conv_busy` is low in that cycle.
- R3: The first trial drives chord 000, step 0000 and `dac_rectify` low, so that the comparator tests the input against zero. The sign bit (word bit 7) becomes 1 when `cmp_ge` is high and 0 when it is low.
- R4: The second trial drives chord 100 with step 0000. Chord bits are resolved from most to least significant with the step field at zero, and then step bits from most to least significant. Each trial sets the bit under test on top of the bits already kept, and the bit is kept only if `cmp_ge` is high.
- R5: During all magnitude trials, `dac_rectify` equals the inverse of the decided sign. During the sign trial it is low.
- R6: With `law_sel` = 0 (mu-law), the word is {sign, ~chord, ~step}. Positive full scale is 8'h80, positive zero is 8'hFF, and negative zero is 8'h7F.
- R7: With `law_sel` = 1 (A-law), the word is {sign, {chord,step} XOR 7'b1010101}. Positive full scale is 8'hAA, positive zero is 8'hD5, and negative full scale is 8'h2A.
- R8: `law_sel` is sampled only at the starting edge. Changing it during a conversion does not alter that conversion's word.
- R9: `conv_start` while busy is ignored. The running conversion keeps its timing and its result.
- R10: `pcm_code` changes only at the edge that raises `conv_done`, and is held until the next completion.
- R11: For a comparator that is monotonic in the trial level, the word encodes the largest (chord c, step s) whose level does not exceed |x|. For mu-law the level is (33·2^c − 33) + s·2^(c+1), so the top decision level is 8031. For A-law the level is 2s when c = 0, and 16·2^c + s·2^c otherwise, so the top decision level is 3968.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Start request, single cycle |
| law_sel | input | 1 | 0 = mu-law, 1 = A-law, sampled at start |
| cmp_ge | input | 1 | Comparator: rectified input at or above trial level |
| dac_chord | output | 3 | Trial chord field to the DAC |
| dac_step | output | 4 | Trial step field to the DAC |
| dac_rectify | output | 1 | Compare the negated input (negative sign decided) |
| conv_busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle completion pulse |
| pcm_code | output | 8 | Companded output word |

## Verification
The assertions assume that `conv_start` may arrive in any cycle and that `cmp_ge` is a fresh combinational answer to the trial currently driven. They do not depend on its value, only on the sequencer advancing one bit per cycle. The bench's comparator model compares a held signed input against the level of the driven code, and it keeps the input inside the selected law's full-scale range (±8159 for mu-law, ±4032 for A-law). Under this model the search is exact, and the word can be predicted by scanning all levels. The input is changed only between conversions, except where the bench deliberately disturbs `law_sel` or `conv_start` mid-conversion.

// File: rtl/sar_enc_pkg.sv
package sar_enc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SIGN = 2'd1,
    PH_MAG  = 2'd2
  } enc_phase_e;

  typedef enum logic {
    LAW_MU = 1'b0,
    LAW_A  = 1'b1
  } law_e;
endpackage

// File: rtl/sar_enc_ctrl.sv
module sar_enc_ctrl
  import sar_enc_pkg::*;
#(
  parameter int MAG_W = 7,
  parameter int IDX_W = $clog2(MAG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output enc_phase_e       phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             last_o,
  output logic             done_o
);
  enc_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q;

  assign accept_o = (phase_q == PH_IDLE) && start_i;
  assign last_o   = (phase_q == PH_MAG) && (idx_q == '0);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_SIGN;
          idx_d   = IDX_W'(MAG_W - 1);
        end
      end
      PH_SIGN: phase_d = PH_MAG;
      PH_MAG: begin
        if (idx_q == '0) phase_d = PH_IDLE;
        else             idx_d   = idx_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      done_q  <= last_o;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;

  // R2: completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R2: an accepted start enters the polarity trial
  a_r2_start_to_sign: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (phase_q == PH_SIGN));
  // R4: the bit under test walks downward one per cycle
  a_r4_idx_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAG && idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1));
  // R9: a running conversion is not restarted
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAG && start_i) |=> (phase_q != PH_SIGN));
endmodule

// File: rtl/sar_enc_bits.sv
module sar_enc_bits
  import sar_enc_pkg::*;
#(
  parameter int MAG_W = 7,
  parameter int IDX_W = $clog2(MAG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  enc_phase_e       phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             accept_i,
  input  logic             cmp_ge_i,
  output logic             sign_o,
  output logic [MAG_W-1:0] trial_o,
  output logic [MAG_W-1:0] mag_fin_o,
  output logic             rectify_o
);
  logic [MAG_W-1:0] mag_q, mag_d, sel;
  logic             mag_en;
  logic             sign_q, sign_d, sign_en;

  for (genvar b = 0; b < MAG_W; b++) begin : g_bit
    assign sel[b]     = (phase_i == PH_MAG) && (idx_i == IDX_W'(b));
    assign mag_d[b]   = accept_i ? 1'b0 : (sel[b] ? cmp_ge_i : mag_q[b]);
    assign trial_o[b] = sel[b] | mag_q[b];
  end

  assign mag_en  = accept_i || (phase_i == PH_MAG);
  assign sign_en = accept_i || (phase_i == PH_SIGN);
  assign sign_d  = accept_i ? 1'b0 : cmp_ge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      sign_q <= 1'b0;
    end else begin
      if (mag_en)  mag_q  <= mag_d;
      if (sign_en) sign_q <= sign_d;
    end
  end

  assign sign_o    = sign_q;
  assign mag_fin_o = mag_d;
  assign rectify_o = (phase_i == PH_MAG) && !sign_q;

  // R4: each magnitude trial adds exactly one bit to the kept bits
  a_r4_one_new_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_MAG) |-> ($countones(trial_o ^ mag_q) == 1));
  // R3: polarity trial drives level zero, unrectified
  a_r3_zero_trial: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_SIGN) |-> (trial_o == '0 && !rectify_o));
  // R5: decided sign is held through the magnitude trials
  a_r5_sign_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_MAG) |=> $stable(sign_q));
endmodule

// File: rtl/sar_enc_format.sv
module sar_enc_format
  import sar_enc_pkg::*;
#(
  parameter int CHORD_W = 3,
  parameter int STEP_W  = 4,
  parameter int MAG_W   = CHORD_W + STEP_W
) (
  input  law_e             law_i,
  input  logic             sign_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W:0]   word_o
);
  logic [MAG_W-1:0] alt_mask;

  for (genvar i = 0; i < MAG_W; i++) begin : g_mask
    assign alt_mask[i] = ((i % 2) == 0);
  end

  always_comb begin
    if (law_i == LAW_A) word_o = {sign_i, mag_i ^ alt_mask};
    else                word_o = {sign_i, ~mag_i};
  end
endmodule

// File: rtl/sar_compand_enc.sv
module sar_compand_enc
  import sar_enc_pkg::*;
#(
  parameter int CHORD_W = 3,
  parameter int STEP_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_start,
  input  logic               law_sel,
  input  logic               cmp_ge,
  output logic [CHORD_W-1:0] dac_chord,
  output logic [STEP_W-1:0]  dac_step,
  output logic               dac_rectify,
  output logic               conv_busy,
  output logic               conv_done,
  output logic [CHORD_W+STEP_W:0] pcm_code
);
  localparam int MAG_W  = CHORD_W + STEP_W;
  localparam int IDX_W  = $clog2(MAG_W);
  localparam int WORD_W = MAG_W + 1;

  logic             rst_s1_q, rst_s2_q, rst_i;
  enc_phase_e       phase;
  logic [IDX_W-1:0] idx;
  logic             accept, last, done;
  logic             sign;
  logic [MAG_W-1:0] trial, mag_fin;
  logic             rectify;
  law_e             law_q;
  logic [WORD_W-1:0] word, code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i = rst_s2_q;

  sar_enc_ctrl #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i),
    .start_i  (conv_start),
    .phase_o  (phase),
    .idx_o    (idx),
    .accept_o (accept),
    .last_o   (last),
    .done_o   (done)
  );

  sar_enc_bits #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_i),
    .phase_i   (phase),
    .idx_i     (idx),
    .accept_i  (accept),
    .cmp_ge_i  (cmp_ge),
    .sign_o    (sign),
    .trial_o   (trial),
    .mag_fin_o (mag_fin),
    .rectify_o (rectify)
  );

  sar_enc_format #(.CHORD_W(CHORD_W), .STEP_W(STEP_W), .MAG_W(MAG_W)) u_fmt (
    .law_i  (law_q),
    .sign_i (sign),
    .mag_i  (mag_fin),
    .word_o (word)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      law_q  <= LAW_MU;
      code_q <= '0;
    end else begin
      if (accept) law_q  <= law_e'(law_sel);
      if (last)   code_q <= word;
    end
  end

  assign dac_chord   = trial[MAG_W-1 -: CHORD_W];
  assign dac_step    = trial[STEP_W-1:0];
  assign dac_rectify = rectify;
  assign conv_busy   = (phase != PH_IDLE);
  assign conv_done   = done;
  assign pcm_code    = code_q;

  // R8: law held for the whole conversion
  a_r8_law_held: assert property (@(posedge clk) disable iff (!rst_i)
    !accept |=> $stable(law_q));
  // R10: output word only moves on completion
  a_r10_code_held: assert property (@(posedge clk) disable iff (!rst_i)
    !last |=> $stable(code_q));
  // R2: no completion pulse while still searching
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_i)
    conv_done |-> !conv_busy);
endmodule

// File: tb/tb_sar_compand_enc.sv
module tb_sar_compand_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_start = 1'b0;
  logic       law_sel = 1'b0;
  logic       cmp_ge;
  logic [2:0] dac_chord;
  logic [3:0] dac_step;
  logic       dac_rectify, conv_busy, conv_done;
  logic [7:0] pcm_code;

  int  x_cur = 0;
  bit  law_m = 1'b0;
  int  n_tests = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  sar_compand_enc dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .law_sel(law_sel),
    .cmp_ge(cmp_ge), .dac_chord(dac_chord), .dac_step(dac_step),
    .dac_rectify(dac_rectify), .conv_busy(conv_busy), .conv_done(conv_done),
    .pcm_code(pcm_code)
  );

  function automatic int lvl(bit law, int c, int s);
    if (!law) return ((33 << c) - 33) + (s << (c + 1));
    if (c == 0) return 2 * s;
    return (16 << c) + (s << c);
  endfunction

  function automatic logic [7:0] expect_code(int x, bit law);
    bit sg = (x >= 0);
    int m = sg ? x : -x;
    int bc = 0;
    int bs = 0;
    logic [6:0] m7;
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 16; s++)
        if (lvl(law, c, s) <= m) begin bc = c; bs = s; end
    m7 = {bc[2:0], bs[3:0]};
    return law ? {sg, m7 ^ 7'h55} : {sg, ~m7};
  endfunction

  always_comb cmp_ge = ((dac_rectify ? -x_cur : x_cur) >=
                        lvl(law_m, int'(dac_chord), int'(dac_step)));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mid: 0 none, 1 extra start mid-run, 2 toggle law mid-run
  task automatic run_conv(int x, bit law, int mid, bit chk_seq);
    int k;
    @(negedge clk);
    x_cur = x; law_m = law; law_sel = law; conv_start = 1'b1;
    k = 0;
    while (k < 20) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        conv_start = 1'b0;
        chk("R2 busy after start", conv_busy, 1);
        if (chk_seq) begin
          chk("R3 sign trial level", {dac_rectify, dac_chord, dac_step}, 0);
        end
      end
      if (k == 2 && chk_seq) begin
        chk("R4 first chord trial", {dac_chord, dac_step}, 7'b1000000);
        chk("R5 rectify", dac_rectify, (x < 0));
      end
      if (k == 3) begin
        if (mid == 1) conv_start = 1'b1;
        if (mid == 2) law_sel = ~law;
      end
      if (k == 4) conv_start = 1'b0;
      if (conv_done) break;
    end
    chk("R2 done timing", k, 9);
    chk("R11 code", pcm_code, expect_code(x, law));
    @(negedge clk);
    chk("R2 done one cycle", conv_done, 0);
    law_sel = law;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {conv_busy, conv_done, pcm_code}, 0);
    chk("R1 reset dac", {dac_rectify, dac_chord, dac_step}, 0);

    run_conv(8159, 0, 0, 1);  chk("R6 mu +full", pcm_code, 8'h80);
    run_conv(0, 0, 0, 1);     chk("R6 mu +zero", pcm_code, 8'hFF);
    run_conv(-1, 0, 0, 1);    chk("R6 mu -zero", pcm_code, 8'h7F);
    run_conv(-8159, 0, 0, 1); chk("R6 mu -full", pcm_code, 8'h00);
    run_conv(4032, 1, 0, 1);  chk("R7 A +full", pcm_code, 8'hAA);
    run_conv(0, 1, 0, 1);     chk("R7 A +zero", pcm_code, 8'hD5);
    run_conv(-4032, 1, 0, 1); chk("R7 A -full", pcm_code, 8'h2A);

    run_conv(lvl(0, 3, 5), 0, 0, 0);      // R11 exact decision level
    run_conv(lvl(0, 3, 5) - 1, 0, 0, 0);  // R11 just below
    run_conv(lvl(1, 1, 0), 1, 0, 0);      // R11 A chord edge
    run_conv(-(lvl(1, 1, 0) - 1), 1, 0, 0);

    run_conv(3000, 0, 1, 0);   // R9 extra start ignored
    run_conv(-700, 1, 1, 0);   // R9
    run_conv(1234, 0, 2, 0);   // R8 law change ignored
    run_conv(-999, 1, 2, 0);   // R8

    held = pcm_code;
    x_cur = -x_cur;
    repeat (6) @(negedge clk);
    chk("R10 code held", pcm_code, held);

    for (int i = 0; i < 60; i++) begin
      bit lw = i[0];
      int span = lw ? 4032 : 8159;
      int xv = int'($urandom_range(0, 2 * span)) - span;
      run_conv(xv, lw, 0, (i % 5) == 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule